// File: doc/BRIEF.md
# Counting Semaphore Cell with Stalling Waiters

This block holds one counting semaphore that several requesters use to synchronise with one another. It is reached through a single register-style access port. Each access carries a view code, a read/write flag, write data and a requester ID. The view code selects how the access acts on the cell. A raw view reads the count directly. A control view holds the tag bits. Two counting views, one blocking and one non-blocking, turn a read into a P (take) operation and a write into a V (give) operation. Codes that would reach a queue cell do nothing here.

A blocking P on a zero count gets no response. The requester's ID is recorded in a mask of blocked requesters. The next V sends a one-cycle wake pulse carrying that mask and clears it. Each woken requester then issues its P again, and the P completes once the count is non-zero. Every access that does not stall is answered one cycle after it is presented, and the response echoes the requester ID.

Top module: `semcell_top`

## Requirements
- R1: After reset the count is zero, all tag bits are clear, the blocked mask is zero, and neither a response nor a wake pulse is asserted.
- R2: An access that does not stall gives `rsp_valid` high for exactly one cycle, in the cycle after the request, with `rsp_id` equal to the request's ID. A write returns data zero.
- R3: A read in view 4 (blocking P) or view 5 (non-blocking P) returns the count as it was before the access. It then decrements the count if that value was above zero.
- R4: A view 5 read on a zero count returns zero, leaves the count and the blocked mask unchanged, and is answered normally.
- R5: A view 4 read on a zero count produces no response and sets bit `req_id` of `blocked_mask`.
- R6: A write in view 4 or 5 is a V operation. It ignores the write data and adds one to the count. The count holds at its all-ones value (0xFFFF at the default width of 16 bits).
- R7: A V operation while `blocked_mask` is non-zero raises `wake_valid` for one cycle, with `wake_mask` equal to the mask as it was before the V, and clears `blocked_mask`. A V operation with an empty mask raises no wake pulse.
- R8: A read in view 0 (raw) returns the count without changing it. A write in view 0 is ignored.
- R9: A read in view 1 (control) returns the empty tag in bit 0, the full tag in bit 1, the tag-event bit in bit 16, and a queue-mode bit in bit 17 that always reads zero. A write in view 1 loads those three tags from bits 0, 1 and 16.
- R10: An access in view 2 or view 3 (the queue views) or in views 6 and 7 returns zero and changes neither the count, the tags nor the blocked mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 3 | View code of the access |
| req_wdata | input | DATA_W | Write data |
| req_id | input | ID_W | Requester ID |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | DATA_W | Read data of the response |
| rsp_id | output | ID_W | Requester ID echoed in the response |
| blocked_mask | output | NUM_REQ | One bit per requester stalled in a blocking P |
| wake_valid | output | 1 | One-cycle wake pulse |
| wake_mask | output | NUM_REQ | Requesters released by the wake pulse |

## Verification
The bench builds the cell with a 4-bit count, 32-bit data and eight requesters. The narrow count lets a run of fewer than twenty V writes reach the saturation point and test the hold at all-ones, then step back down through P reads. The eight requesters let two different IDs stall at the same time, so the bench can check that the wake pulse carries both bits together before the mask clears.

// File: rtl/semcell_pkg.sv
package semcell_pkg;

   typedef enum logic [2:0] {
      VW_RAW   = 3'd0,
      VW_CTRL  = 3'd1,
      VW_QSYNC = 3'd2,
      VW_QTRY  = 3'd3,
      VW_PSYNC = 3'd4,
      VW_PTRY  = 3'd5
   } view_e;

   typedef struct packed {
      logic evt;
      logic full;
      logic empty;
   } tag_t;

   localparam int TAG_EMPTY_BIT = 0;
   localparam int TAG_FULL_BIT  = 1;
   localparam int TAG_EVT_BIT   = 16;
   localparam int TAG_QMODE_BIT = 17;

endpackage

// File: rtl/semcell_counter.sv
module semcell_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_width
      $error("semcell_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (inc && (cnt_q != CNT_MAX)) begin
         cnt_q <= cnt_q + 1'b1;
      end else if (dec && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assert_sat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

   assert_dec_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   assert_zero_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !inc && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/semcell_blocker.sv
module semcell_blocker #(
   parameter int NUM_REQ = 8,
   parameter int ID_W    = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               block_en,
   input  logic [ID_W-1:0]    block_id,
   input  logic               give_en,
   output logic [NUM_REQ-1:0] blocked_q,
   output logic               wake_valid_q,
   output logic [NUM_REQ-1:0] wake_mask_q
);
   if ((1 << ID_W) < NUM_REQ) begin : g_bad_id
      $error("semcell_blocker: ID_W too narrow for NUM_REQ");
   end

   for (genvar g = 0; g < NUM_REQ; g++) begin : g_req
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            blocked_q[g] <= 1'b0;
         end else if (give_en) begin
            blocked_q[g] <= 1'b0;
         end else if (block_en && (block_id == ID_W'(g))) begin
            blocked_q[g] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wake_valid_q <= 1'b0;
         wake_mask_q  <= '0;
      end else begin
         wake_valid_q <= give_en && (blocked_q != '0);
         wake_mask_q  <= (give_en && (blocked_q != '0)) ? blocked_q : '0;
      end
   end

   assert_wake_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      give_en |=> (blocked_q == '0));

   assert_wake_carries_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (give_en && blocked_q != '0) |=> (wake_valid_q && wake_mask_q == $past(blocked_q)));

   assert_wake_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid_q |=> !wake_valid_q);

endmodule

// File: rtl/semcell_resp.sv
module semcell_resp #(
   parameter int DATA_W = 32,
   parameter int ID_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic [DATA_W-1:0] rdata,
   input  logic [ID_W-1:0]   id,
   output logic              rsp_valid_q,
   output logic [DATA_W-1:0] rsp_rdata_q,
   output logic [ID_W-1:0]   rsp_id_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= 1'b0;
         rsp_rdata_q <= '0;
         rsp_id_q    <= '0;
      end else begin
         rsp_valid_q <= fire;
         if (fire) begin
            rsp_rdata_q <= rdata;
            rsp_id_q    <= id;
         end
      end
   end
endmodule

// File: rtl/semcell_top.sv
module semcell_top #(
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 16,
   parameter int NUM_REQ = 8,
   parameter int ID_W    = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic [2:0]         req_view,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic [ID_W-1:0]    req_id,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_rdata,
   output logic [ID_W-1:0]    rsp_id,
   output logic [NUM_REQ-1:0] blocked_mask,
   output logic               wake_valid,
   output logic [NUM_REQ-1:0] wake_mask
);
   import semcell_pkg::*;

   if (DATA_W < semcell_pkg::TAG_QMODE_BIT + 1) begin : g_bad_data
      $error("semcell_top: DATA_W too narrow for control word");
   end
   if (CNT_W > DATA_W) begin : g_bad_cnt
      $error("semcell_top: CNT_W exceeds DATA_W");
   end

   logic [CNT_W-1:0] cnt;
   tag_t             tag_q;
   logic             pv_view, p_op, v_op, p_block;
   logic [DATA_W-1:0] rd_data;

   assign pv_view = (req_view == VW_PSYNC) || (req_view == VW_PTRY);
   assign p_op    = req_valid && !req_write && pv_view;
   assign v_op    = req_valid &&  req_write && pv_view;
   assign p_block = p_op && (req_view == VW_PSYNC) && (cnt == '0);

   semcell_counter #(.CNT_W(CNT_W)) counter_i (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (v_op),
      .dec   (p_op),
      .cnt_q (cnt)
   );

   semcell_blocker #(.NUM_REQ(NUM_REQ), .ID_W(ID_W)) blocker_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .block_en     (p_block),
      .block_id     (req_id),
      .give_en      (v_op),
      .blocked_q    (blocked_mask),
      .wake_valid_q (wake_valid),
      .wake_mask_q  (wake_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
      end else if (req_valid && req_write && req_view == VW_CTRL) begin
         tag_q.evt   <= req_wdata[TAG_EVT_BIT];
         tag_q.full  <= req_wdata[TAG_FULL_BIT];
         tag_q.empty <= req_wdata[TAG_EMPTY_BIT];
      end
   end

   always_comb begin
      rd_data = '0;
      if (!req_write) begin
         case (req_view)
            VW_RAW, VW_PSYNC, VW_PTRY: rd_data[CNT_W-1:0] = cnt;
            VW_CTRL: begin
               rd_data[TAG_EVT_BIT]   = tag_q.evt;
               rd_data[TAG_FULL_BIT]  = tag_q.full;
               rd_data[TAG_EMPTY_BIT] = tag_q.empty;
               rd_data[TAG_QMODE_BIT] = 1'b0;
            end
            default: rd_data = '0;
         endcase
      end
   end

   semcell_resp #(.DATA_W(DATA_W), .ID_W(ID_W)) resp_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .fire        (req_valid && !p_block),
      .rdata       (rd_data),
      .id          (req_id),
      .rsp_valid_q (rsp_valid),
      .rsp_rdata_q (rsp_rdata),
      .rsp_id_q    (rsp_id)
   );

   assert_stall_no_rsp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      p_block |=> (!rsp_valid && blocked_mask[$past(req_id)]));

   assert_rsp_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !p_block) |=> (rsp_valid && rsp_id == $past(req_id)));

   assert_p_old_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (p_op && !p_block) |=> (rsp_rdata[CNT_W-1:0] == $past(cnt)));

   assert_raw_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_view == VW_RAW) |=> $stable(cnt));

endmodule

// File: tb/semcell_top_tb_top.sv
module semcell_top_tb_top;
   localparam int DW = 32;
   localparam int CW = 4;
   localparam int NR = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [2:0]    req_view = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [IW-1:0] req_id = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic [IW-1:0] rsp_id;
   logic [NR-1:0] blocked_mask;
   logic          wake_valid;
   logic [NR-1:0] wake_mask;

   int n_checks = 0;
   int n_fail   = 0;
   logic          s_valid, s_wake;
   logic [DW-1:0] s_data;
   logic [IW-1:0] s_id;
   logic [NR-1:0] s_wmask;

   always #4 clk = ~clk;

   semcell_top #(.DATA_W(DW), .CNT_W(CW), .NUM_REQ(NR), .ID_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_view(req_view), .req_wdata(req_wdata), .req_id(req_id),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_id(rsp_id),
      .blocked_mask(blocked_mask), .wake_valid(wake_valid), .wake_mask(wake_mask));

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic access(input logic wr, input logic [2:0] view,
                         input logic [DW-1:0] wd, input logic [IW-1:0] id);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_view = view; req_wdata = wd; req_id = id;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      s_valid = rsp_valid; s_data = rsp_rdata; s_id = rsp_id;
      s_wake = wake_valid; s_wmask = wake_mask;
   endtask

   task automatic raw_count(input string req, input logic [DW-1:0] exp);
      access(1'b0, 3'd0, '0, 3'd0);
      check(req, s_data, exp);
   endtask

   task automatic t_reset;
      check("R1 rsp_valid", {31'd0, rsp_valid}, 0);
      check("R1 wake_valid", {31'd0, wake_valid}, 0);
      check("R1 blocked", {24'd0, blocked_mask}, 0);
      access(1'b0, 3'd1, '0, 3'd2);
      check("R1 tags", s_data, 0);
      raw_count("R1 count", 0);
   endtask

   task automatic t_try_zero;
      access(1'b0, 3'd5, '0, 3'd6);
      check("R4 try rsp", {31'd0, s_valid}, 1);
      check("R2 id echo", {29'd0, s_id}, 6);
      check("R4 try data", s_data, 0);
      check("R4 blocked", {24'd0, blocked_mask}, 0);
      raw_count("R4 count", 0);
   endtask

   task automatic t_block_and_wake;
      access(1'b0, 3'd4, '0, 3'd3);
      check("R5 no rsp", {31'd0, s_valid}, 0);
      check("R5 mask", {24'd0, blocked_mask}, 32'h08);
      access(1'b0, 3'd4, '0, 3'd5);
      check("R5 mask two", {24'd0, blocked_mask}, 32'h28);
      access(1'b1, 3'd4, 32'hDEAD, 3'd1);
      check("R2 write rsp", {31'd0, s_valid}, 1);
      check("R2 write data", s_data, 0);
      check("R7 wake", {31'd0, s_wake}, 1);
      check("R7 wake mask", {24'd0, s_wmask}, 32'h28);
      check("R7 cleared", {24'd0, blocked_mask}, 0);
      @(negedge clk);
      check("R7 one cycle", {31'd0, wake_valid}, 0);
      raw_count("R6 count ignores data", 1);
      access(1'b1, 3'd5, 32'h5, 3'd2);
      check("R7 no wake empty", {31'd0, s_wake}, 0);
      raw_count("R6 count two", 2);
   endtask

   task automatic t_take;
      access(1'b0, 3'd4, '0, 3'd3);
      check("R3 sync rsp", {31'd0, s_valid}, 1);
      check("R3 old value", s_data, 2);
      access(1'b0, 3'd5, '0, 3'd4);
      check("R3 try old value", s_data, 1);
      raw_count("R3 decremented", 0);
   endtask

   task automatic t_raw_and_queue;
      access(1'b1, 3'd5, '0, 3'd0);
      access(1'b1, 3'd0, 32'h9, 3'd0);
      raw_count("R8 raw write ignored", 1);
      access(1'b1, 3'd2, 32'h77, 3'd0);
      check("R10 q write rsp", {31'd0, s_valid}, 1);
      access(1'b0, 3'd3, '0, 3'd0);
      check("R10 q read", s_data, 0);
      access(1'b0, 3'd2, '0, 3'd1);
      check("R10 q sync read", s_data, 0);
      check("R10 no block", {24'd0, blocked_mask}, 0);
      access(1'b0, 3'd7, '0, 3'd0);
      check("R10 view7 read", s_data, 0);
      raw_count("R10 count kept", 1);
   endtask

   task automatic t_control;
      access(1'b1, 3'd1, 32'hFFFF_FFFF, 3'd0);
      access(1'b0, 3'd1, '0, 3'd0);
      check("R9 tags set", s_data, 32'h0001_0003);
      access(1'b1, 3'd1, 32'h0001_0000, 3'd0);
      access(1'b0, 3'd1, '0, 3'd0);
      check("R9 tags partial", s_data, 32'h0001_0000);
      raw_count("R9 count kept", 1);
   endtask

   task automatic t_saturate;
      for (int i = 0; i < 20; i++) access(1'b1, 3'd4, '0, 3'd0);
      raw_count("R6 saturated", 15);
      access(1'b0, 3'd5, '0, 3'd0);
      check("R3 from max", s_data, 15);
      raw_count("R3 after max", 14);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_try_zero();
      t_block_and_wake();
      t_take();
      t_raw_and_queue();
      t_control();
      t_saturate();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule